// File: doc/BRIEF.md
# Character LCD Host Instruction Interface

This block is the host-side instruction port of a character dot-matrix display controller. A host drives a one-cycle strobe together with a register-select line, a read/write line and an 8-bit data byte. The block decodes these into a status read, two address-load commands, an entry-mode command, a data write and a data read, and it holds the state they act on. That state is a shared address counter, the flag that says which RAM it points into, the stepping direction and a busy timer. The display data RAM (128 x 8) and the character-generator RAM (32 x 5) sit inside the block as plain register arrays.

The host polls the status byte until the busy bit is low before it sends the next instruction. An instruction that is not a status read and arrives while the block is busy is dropped. Read results, both status and RAM data, appear on `dout` in the cycle after the strobe and stay there until the next accepted read.

Top module: `chlcd_host_port`

## Requirements
- R1: A strobe with rs=0, rw=1 is a status read, and it is accepted even while busy. From the next cycle `dout` bit 7 is the busy flag and bits 6..0 are the address counter.
- R2: While the character-generator RAM is selected, counter bits 6..5 read as 0 and the counter wraps modulo 32 in both directions.
- R3: While the display RAM is selected, the counter wraps modulo 128 in both directions (127+1 gives 0, and 0-1 gives 127).
- R4: A command (rs=0, rw=0) with din[7]=1 loads din[6:0] into the counter and selects the display RAM.
- R5: A command with din[7:6]=01 loads din[4:0] into the counter, clears counter bits 6..5 and selects the character-generator RAM.
- R6: A command with din[7:3]=00000 and din[2]=1 sets the stepping direction: din[1]=1 counts up and din[1]=0 counts down.
- R7: A data write (rs=1, rw=0) stores din[7:0] into display RAM, or only din[4:0] into character-generator RAM, at the counter. The counter then moves by exactly 1 in the set direction.
- R8: A data read (rs=1, rw=1) puts the word at the counter on `dout` from the next cycle. A character-generator word comes out with bits 7..5 equal to 0. The counter then moves by 1 in the set direction.
- R9: Every accepted instruction other than a status read holds the busy flag high for exactly BUSY_CYCLES cycles, starting in the next cycle.
- R10: An instruction other than a status read that is strobed while busy has no effect on the RAMs, the counter, the RAM selection, the direction, `dout` or the busy timing.
- R11: After reset the display RAM is selected, the counter is 0, the direction is up and the busy flag is low.
- R12: A command byte that matches none of the codes in R4, R5 and R6 (for example 0x01 or 0x20) changes no state and does not set the busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stb | input | 1 | One-cycle access strobe |
| rs | input | 1 | Register select: 0 selects a command or status access, 1 selects a data access |
| rw | input | 1 | 1 for read, 0 for write |
| din | input | 8 | Byte from the host |
| dout | output | 8 | Status or RAM read result, held until the next accepted read |

## Verification
Four properties are checked on every cycle: an accepted instruction raises the busy flag, the busy timer stays within its bound, the upper counter bits stay 0 while the character-generator RAM is selected, and a busy-time strobe leaves `dout` unchanged. A status read taken while busy shows the flag, and every data access moves the counter. Only the bench's scenarios can show the rest. That covers the stored contents across full RAM sweeps in both directions, the wrap points at 127/0 and 31/0, the masking of character-generator data, the exact length of the busy window, and the commands that are dropped or not recognised.

// File: rtl/chlcd_pkg.sv
package chlcd_pkg;
  localparam int BUS_W = 8;
  localparam int DD_AW = 7;
  localparam int CG_AW = 5;
  localparam int DD_DW = 8;
  localparam int CG_DW = 5;

  typedef enum logic [2:0] {
    OP_NONE, OP_STATUS, OP_DD_SET, OP_CG_SET, OP_ENTRY, OP_WRITE, OP_READ
  } op_e;

  // Next counter value after a data access; in character-generator mode the
  // counter lives in the low CG_AW bits and wraps there.
  function automatic logic [DD_AW-1:0] step_addr(input logic [DD_AW-1:0] a,
                                                 input logic up, input logic cg);
    logic [DD_AW-1:0] n;
    n = up ? a + 1'b1 : a - 1'b1;
    if (cg) n = {{(DD_AW-CG_AW){1'b0}}, n[CG_AW-1:0]};
    return n;
  endfunction
endpackage

// File: rtl/chlcd_decode.sv
module chlcd_decode
  import chlcd_pkg::*;
(
  input  logic             stb,
  input  logic             rs,
  input  logic             rw,
  input  logic [BUS_W-1:0] din,
  output op_e              op
);
  always_comb begin
    op = OP_NONE;
    if (stb) begin
      unique case ({rs, rw})
        2'b01: op = OP_STATUS;
        2'b10: op = OP_WRITE;
        2'b11: op = OP_READ;
        default: begin
          if (din[7])                          op = OP_DD_SET;
          else if (din[6])                     op = OP_CG_SET;
          else if (din[5:3] == 3'b000 && din[2]) op = OP_ENTRY;
          else                                 op = OP_NONE;
        end
      endcase
    end
  end
endmodule

// File: rtl/chlcd_busy.sv
module chlcd_busy #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= CW'(CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  a_r9_load_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(CYC));
endmodule

// File: rtl/chlcd_addr.sv
module chlcd_addr
  import chlcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  op_e              op_acc,
  input  logic [BUS_W-1:0] din,
  output logic [DD_AW-1:0] ac,
  output logic             cg_sel,
  output logic             dir_up
);
  logic step_evt;
  assign step_evt = (op_acc == OP_WRITE) || (op_acc == OP_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac     <= '0;
      cg_sel <= 1'b0;
      dir_up <= 1'b1;
    end else begin
      unique case (op_acc)
        OP_DD_SET: begin
          ac     <= din[DD_AW-1:0];
          cg_sel <= 1'b0;
        end
        OP_CG_SET: begin
          ac     <= {{(DD_AW-CG_AW){1'b0}}, din[CG_AW-1:0]};
          cg_sel <= 1'b1;
        end
        OP_ENTRY: dir_up <= din[1];
        OP_WRITE, OP_READ: ac <= step_addr(ac, dir_up, cg_sel);
        default: ;
      endcase
    end
  end

  a_r2_cg_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cg_sel |-> ac[DD_AW-1:CG_AW] == '0);
  a_r7_access_moves: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> ac != $past(ac));
endmodule

// File: rtl/chlcd_ram.sv
module chlcd_ram #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/chlcd_host_port.sv
module chlcd_host_port
  import chlcd_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             rs,
  input  logic             rw,
  input  logic [BUS_W-1:0] din,
  output logic [BUS_W-1:0] dout
);
  op_e              op_raw, op_acc;
  logic             busy, load, cg_sel, dir_up;
  logic [DD_AW-1:0] ac;
  logic [DD_DW-1:0] dd_rd;
  logic [CG_DW-1:0] cg_rd;
  logic             dd_we, cg_we;

  chlcd_decode u_dec (.stb(stb), .rs(rs), .rw(rw), .din(din), .op(op_raw));

  // Status reads always pass; everything else only when idle.
  always_comb begin
    op_acc = OP_NONE;
    if (op_raw == OP_STATUS)                  op_acc = OP_STATUS;
    else if (op_raw != OP_NONE && !busy)      op_acc = op_raw;
  end

  assign load  = (op_acc != OP_NONE) && (op_acc != OP_STATUS);
  assign dd_we = (op_acc == OP_WRITE) && !cg_sel;
  assign cg_we = (op_acc == OP_WRITE) &&  cg_sel;

  chlcd_busy #(.CYC(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .load(load), .busy(busy));

  chlcd_addr u_addr (
    .clk(clk), .rst_n(rst_n), .op_acc(op_acc), .din(din),
    .ac(ac), .cg_sel(cg_sel), .dir_up(dir_up));

  chlcd_ram #(.AW(DD_AW), .DW(DD_DW)) u_dd (
    .clk(clk), .we(dd_we), .addr(ac), .wdata(din[DD_DW-1:0]), .rdata(dd_rd));

  chlcd_ram #(.AW(CG_AW), .DW(CG_DW)) u_cg (
    .clk(clk), .we(cg_we), .addr(ac[CG_AW-1:0]), .wdata(din[CG_DW-1:0]),
    .rdata(cg_rd));

  always_ff @(posedge clk) begin
    if (!rst_n) dout <= '0;
    else if (op_acc == OP_STATUS) dout <= {busy, ac};
    else if (op_acc == OP_READ)
      dout <= cg_sel ? {{(BUS_W-CG_DW){1'b0}}, cg_rd} : dd_rd;
  end

  a_r1_status_shows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !rs && rw && busy) |=> dout[BUS_W-1]);
  a_r10_busy_keeps_dout: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !(!rs && rw) && busy) |=> $stable(dout));
endmodule

// File: tb/chlcd_host_port_tb.sv
module chlcd_host_port_tb;
  localparam int B = 4;
  logic clk = 1'b0, rst_n = 1'b0, stb = 1'b0, rs = 1'b0, rw = 1'b0;
  logic [7:0] din = '0, dout, q;
  int checks = 0, errors = 0;
  logic [7:0] ddm [128];
  logic [4:0] cgm [32];

  always #5 clk = ~clk;

  chlcd_host_port #(.BUSY_CYCLES(B)) u_dut (
    .clk(clk), .rst_n(rst_n), .stb(stb), .rs(rs), .rw(rw), .din(din), .dout(dout));

  function automatic logic [7:0] dpat(input int a);
    return 8'((a * 37 + 5) % 256);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Starts at a negedge; strobe lands on the next posedge; returns at the negedge after.
  task automatic strobe(input logic r_s, input logic r_w, input logic [7:0] d,
                        output logic [7:0] res);
    stb = 1'b1; rs = r_s; rw = r_w; din = d;
    @(posedge clk);
    @(negedge clk);
    stb = 1'b0;
    res = dout;
  endtask

  task automatic op(input logic r_s, input logic r_w, input logic [7:0] d,
                    output logic [7:0] res);
    strobe(r_s, r_w, d, res);
    if (!(r_s == 1'b0 && r_w == 1'b1)) begin
      repeat (B) @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic status(output logic [7:0] res);
    strobe(1'b0, 1'b1, 8'h00, res);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    status(q); chk("R11 reset status", q, 8'h00);

    // R6 up, R4 set, R7 write sweep, R3 wrap
    op(0, 0, 8'h06, q);
    op(0, 0, 8'h80, q);
    for (int a = 0; a < 128; a++) begin
      op(1, 0, dpat(a), q);
      ddm[a] = dpat(a);
      if (a == 0) begin status(q); chk("R7 step up after write", q, 8'h01); end
    end
    status(q); chk("R3 wrap 127 to 0", q, 8'h00);
    op(0, 0, 8'h80 | 8'd50, q);
    status(q); chk("R4 dd address set", q, 8'd50);
    op(0, 0, 8'h80, q);
    for (int a = 0; a < 128; a++) begin
      op(1, 1, 8'h00, q);
      chk("R8 dd read data", q, ddm[a]);
    end
    status(q); chk("R8 read steps and wraps", q, 8'h00);

    // R6 down, R3 wrap 0 to 127
    op(0, 0, 8'h04, q);
    op(0, 0, 8'h80, q);
    op(1, 0, 8'hAA, q); ddm[0] = 8'hAA;
    status(q); chk("R3 wrap 0 to 127", q, 8'h7F);
    op(1, 1, 8'h00, q); chk("R8 read at 127", q, ddm[127]);
    status(q); chk("R6 down step after read", q, 8'h7E);

    // R5 cg set, R2 wrap and upper bits, R7 masked writes (down)
    op(0, 0, 8'h7F, q);
    status(q); chk("R5 cg set loads low bits", q, 8'h1F);
    for (int i = 0; i < 32; i++) begin
      logic [7:0] v;
      v = 8'((i * 7 + 3) % 256) | 8'hE0;
      op(1, 0, v, q);
      cgm[31 - i] = v[4:0];
    end
    status(q); chk("R2 cg wrap 0 to 31", q, 8'h1F);
    op(0, 0, 8'h06, q);
    op(0, 0, 8'h40, q);
    for (int a = 0; a < 32; a++) begin
      op(1, 1, 8'h00, q);
      chk("R8 cg read masked", q, {3'b000, cgm[a]});
    end
    status(q); chk("R2 cg wrap 31 to 0", q, 8'h00);
    op(0, 0, 8'h80 | 8'd1, q);
    op(1, 1, 8'h00, q); chk("R4 dd reselect keeps dd data", q, ddm[1]);

    // R9 busy window length, R1 status while busy
    op(0, 0, 8'h80 | 8'd20, q);
    strobe(1, 0, 8'h5C, q); ddm[20] = 8'h5C;
    for (int j = 1; j <= B; j++) begin
      status(q); chk("R9 R1 busy during window", q, 8'h80 | 8'd21);
    end
    status(q); chk("R9 busy cleared after window", q, 8'd21);

    // R10 ignored while busy
    op(0, 0, 8'h80 | 8'd5, q);
    status(q); prev = q;
    strobe(1, 0, 8'h11, q); ddm[5] = 8'h11;
    strobe(1, 0, 8'h22, q);
    strobe(0, 0, 8'h90, q);
    strobe(0, 0, 8'h04, q);
    strobe(1, 1, 8'h00, q); chk("R10 busy read leaves dout", q, prev);
    repeat (B) @(posedge clk); @(negedge clk);
    status(q); chk("R10 counter untouched", q, 8'd6);
    op(1, 0, 8'h33, q); ddm[6] = 8'h33;
    status(q); chk("R10 direction still up", q, 8'd7);
    op(0, 0, 8'h80 | 8'd5, q);
    op(1, 1, 8'h00, q); chk("R10 second write dropped", q, 8'h11);
    op(1, 1, 8'h00, q); chk("R7 next write stored", q, 8'h33);

    // R12 unknown commands
    op(0, 0, 8'h80 | 8'd10, q);
    strobe(0, 0, 8'h01, q);
    status(q); chk("R12 0x01 no busy no change", q, 8'd10);
    strobe(0, 0, 8'h20, q);
    status(q); chk("R12 0x20 no busy no change", q, 8'd10);
    op(1, 1, 8'h00, q); chk("R12 selection kept", q, ddm[10]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule